// File: doc/BRIEF.md
# Paired-Word Parcel Assembler

This block takes a stream of 32-bit words that come in aligned pairs. Each pair packs three 17-bit parcels. A start bit attached to each parcel marks where an instruction begins. The block joins consecutive parcels into instructions of one to `MAXP` parcels. It presents each finished instruction on a wide bus with its first parcel in the most significant position, together with a parcel count.

A word is a first word if its five top bits read 11110, and a second word if they read 11111. The middle parcel of each pair is split across the two words: eight bits come from the first word and nine from the second. An instruction is complete when the next parcel carrying a start bit arrives, and it is emitted at that point.

Wrong word prefixes, continuation parcels that arrive with no instruction open, and instructions longer than the limit each produce a one-cycle error pulse. Input and output both use valid/ready handshakes. When the output is held back, the block stops taking input words and no parcel is dropped.

Top module: `parcel_asm`

## Requirements
- R1: During and right after reset, `out_valid` and `err` are low and `in_ready` is high.
- R2: A first word has prefix 11110 in bits 31:27, the start bits of parcels 0 and 1 in bits 26 and 25, parcel 0 in bits 24:8, and the upper eight bits of parcel 1 in bits 7:0.
- R3: A second word has prefix 11111 in bits 31:27, the start bit of parcel 2 in bit 26, the lower nine bits of parcel 1 in bits 25:17, and parcel 2 in bits 16:0.
- R4: Parcels are taken in the order parcel 0, 1, 2 of each pair, pair after pair. An instruction covers the parcels from one set start bit up to the parcel just before the next set start bit, and it is emitted when that next start bit is seen.
- R5: On output, parcel 0 of the instruction sits in bits `[17*MAXP-1 -: 17]` and each later parcel sits 17 bits lower. Unused positions are zero. `out_count` holds the number of parcels, from 1 to `MAXP`.
- R6: A word whose prefix does not match its expected pair position pulses `err` for one cycle and drops any partial instruction. If a second word was expected and the word reads 11110, it is kept as a new first word; in every other case the word is discarded and a first word is expected next.
- R7: A parcel with a clear start bit that arrives while no instruction is open pulses `err` once for each such parcel, and nothing is emitted for it.
- R8: A continuation parcel that would make an instruction longer than `MAXP` parcels pulses `err` once and drops the instruction. Further continuation parcels are then ignored without error until the next set start bit.
- R9: While `out_valid` is high and `out_ready` is low, the output holds stable. The block stops accepting input rather than losing any parcel or instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word |
| in_ready | output | 1 | Block accepts a word this cycle |
| out_valid | output | 1 | Assembled instruction valid |
| out_ready | input | 1 | Consumer accepts the instruction |
| out_insn | output | 17*MAXP | Assembled instruction, parcel 0 left-aligned |
| out_count | output | $clog2(MAXP+1) | Number of parcels in the instruction |
| err | output | 1 | One-cycle error pulse |

## Verification
A wrong pair phase shows first as an `err` pulse at the next word, one cycle after that word is accepted. Parcels that are misassembled or taken out of order, including a wrong join of the split parcel, show up in the emitted bus and count of the very next instruction, which is compared parcel by parcel with a model of the start bits. A stale length counter or a stuck drop flag shows up as a wrong count or as missing or extra `err` pulses, which are tallied against hand-derived totals for each scenario.

// File: rtl/parcel_asm.sv
module parcel_asm #(
  parameter int MAXP = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [31:0]                  in_data,
  output logic                         in_ready,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [17*MAXP-1:0]           out_insn,
  output logic [$clog2(MAXP+1)-1:0]    out_count,
  output logic                         err
);
  localparam int PW = 17;
  localparam int OW = PW * MAXP;
  localparam int CW = $clog2(MAXP + 1);
  localparam logic [4:0] PFX_A = 5'b11110;
  localparam logic [4:0] PFX_B = 5'b11111;

  typedef enum logic [1:0] {S_A, S_B, S_P} st_t;

  st_t           st;
  logic [1:0]    pi;
  logic [26:0]   wa, wb;
  logic [OW-1:0] acc;
  logic [CW-1:0] cnt;
  logic          busy, drop;
  logic          pflag;
  logic [PW-1:0] pval;

  always_comb begin
    unique case (pi)
      2'd0:    begin pflag = wa[26]; pval = wa[24:8]; end
      2'd1:    begin pflag = wa[25]; pval = {wa[7:0], wb[25:17]}; end
      default: begin pflag = wb[26]; pval = wb[16:0]; end
    endcase
  end

  wire take  = in_valid && in_ready;
  wire stall = (st == S_P) && pflag && busy && out_valid && !out_ready;
  wire emit  = (st == S_P) && pflag && busy && !stall;
  wire [4:0] pfx = in_data[31:27];

  assign in_ready = (st != S_P);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_A;
      pi        <= 2'd0;
      wa        <= '0;
      wb        <= '0;
      acc       <= '0;
      cnt       <= '0;
      busy      <= 1'b0;
      drop      <= 1'b0;
      out_valid <= 1'b0;
      out_insn  <= '0;
      out_count <= '0;
      err       <= 1'b0;
    end else begin
      err <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (emit) begin
        out_valid <= 1'b1;
        out_insn  <= acc;
        out_count <= cnt;
      end
      unique case (st)
        S_A: if (take) begin
          if (pfx == PFX_A) begin
            wa <= in_data[26:0];
            st <= S_B;
          end else begin
            err  <= 1'b1;
            busy <= 1'b0;
            drop <= 1'b0;
          end
        end
        S_B: if (take) begin
          if (pfx == PFX_B) begin
            wb <= in_data[26:0];
            st <= S_P;
            pi <= 2'd0;
          end else begin
            err  <= 1'b1;
            busy <= 1'b0;
            drop <= 1'b0;
            if (pfx == PFX_A) wa <= in_data[26:0];
            else              st <= S_A;
          end
        end
        default: if (!stall) begin
          if (pflag) begin
            acc  <= {pval, {(OW-PW){1'b0}}};
            cnt  <= CW'(1);
            busy <= 1'b1;
            drop <= 1'b0;
          end else if (busy) begin
            if (cnt == CW'(MAXP)) begin
              err  <= 1'b1;
              busy <= 1'b0;
              drop <= 1'b1;
            end else begin
              acc[(MAXP-1-int'(cnt))*PW +: PW] <= pval;
              cnt <= cnt + 1'b1;
            end
          end else if (!drop) begin
            err <= 1'b1;
          end
          if (pi == 2'd2) begin
            st <= S_A;
            pi <= 2'd0;
          end else begin
            pi <= pi + 2'd1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/parcel_asm_chk.sv
module parcel_asm_chk #(
  parameter int MAXP = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic [4:0]                in_pfx,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [17*MAXP-1:0]        out_insn,
  input logic [$clog2(MAXP+1)-1:0] out_count,
  input logic                      err
);
  localparam int OW = 17 * MAXP;
  logic [OW-1:0] tailmask;
  assign tailmask = {OW{1'b1}} >> (int'(out_count) * 17);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && !err && in_ready));

  p_bad_prefix_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_pfx[4:1] != 4'hF) |=> err);

  p_count_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_count != '0 && int'(out_count) <= MAXP));

  p_tail_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_insn & tailmask) == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_insn) && $stable(out_count)));
endmodule

bind parcel_asm parcel_asm_chk #(.MAXP(MAXP)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_pfx(in_data[31:27]), .out_valid(out_valid), .out_ready(out_ready),
  .out_insn(out_insn), .out_count(out_count), .err(err)
);

// File: tb/parcel_asm_tb.sv
module parcel_asm_tb;
  localparam int MAXP = 8;
  localparam int OW = 17 * MAXP;
  localparam int CW = $clog2(MAXP + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, err;
  logic [OW-1:0] out_insn;
  logic [CW-1:0] out_count;

  always #4 clk = ~clk;

  parcel_asm #(.MAXP(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_insn(out_insn), .out_count(out_count), .err(err)
  );

  int n_cmp = 0, n_bad = 0, err_seen = 0, experr = 0;
  bit mon_on = 0;
  int bp_pct = 50;
  logic [31:0] stim[$];
  logic [OW-1:0] exp_i[$];
  int exp_c[$];

  int mph = 0, mcnt = 0;
  bit mbusy = 0, mdrop = 0;
  logic [26:0] mw0 = '0;
  logic [OW-1:0] macc = '0;

  task automatic chk_int(string req, int act, int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [31:0] mk_a(bit f0, bit f1, logic [16:0] p0, logic [16:0] p1);
    return {5'b11110, f0, f1, p0, p1[16:9]};
  endfunction
  function automatic logic [31:0] mk_b(bit f2, logic [16:0] p1, logic [16:0] p2);
    return {5'b11111, f2, p1[8:0], p2};
  endfunction
  task automatic pair(bit f0, bit f1, bit f2);
    logic [16:0] p0 = 17'($urandom), p1 = 17'($urandom), p2 = 17'($urandom);
    stim.push_back(mk_a(f0, f1, p0, p1));
    stim.push_back(mk_b(f2, p1, p2));
  endtask

  task automatic model_parcel(bit f, logic [16:0] p);
    if (f) begin
      if (mbusy) begin exp_i.push_back(macc); exp_c.push_back(mcnt); end
      macc = '0; macc[OW-1 -: 17] = p; mcnt = 1; mbusy = 1; mdrop = 0;
    end else if (mbusy) begin
      if (mcnt == MAXP) begin experr++; mbusy = 0; mdrop = 1; end
      else begin macc[(MAXP-1-mcnt)*17 +: 17] = p; mcnt++; end
    end else if (!mdrop) experr++;
  endtask

  task automatic model_word(logic [31:0] w);
    if (mph == 0) begin
      if (w[31:27] == 5'b11110) begin mw0 = w[26:0]; mph = 1; end
      else begin experr++; mbusy = 0; mdrop = 0; end
    end else if (w[31:27] == 5'b11111) begin
      model_parcel(mw0[26], mw0[24:8]);
      model_parcel(mw0[25], {mw0[7:0], w[25:17]});
      model_parcel(w[26], w[16:0]);
      mph = 0;
    end else begin
      experr++; mbusy = 0; mdrop = 0;
      if (w[31:27] == 5'b11110) mw0 = w[26:0];
      else mph = 0;
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    if (err) err_seen++;
    out_ready = ($urandom_range(99) < bp_pct);
    if (out_valid && out_ready) begin
      n_cmp++;
      if (exp_i.size() == 0) begin
        n_bad++;
        $display("FAIL R4 unexpected output actual=%h/%0d expected=none", out_insn, out_count);
      end else begin
        if (out_insn !== exp_i[0] || int'(out_count) != exp_c[0]) begin
          n_bad++;
          $display("FAIL R5 actual=%h/%0d expected=%h/%0d", out_insn, out_count, exp_i[0], exp_c[0]);
        end
        void'(exp_i.pop_front());
        void'(exp_c.pop_front());
      end
    end
  end

  task automatic run(string req, int want_err);
    int e0 = err_seen, m0 = experr;
    while (stim.size() > 0) begin
      @(negedge clk);
      in_valid = ($urandom_range(99) < 80);
      in_data = stim[0];
      if (in_valid && in_ready) begin
        model_word(stim[0]);
        void'(stim.pop_front());
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < 400 && exp_i.size() > 0; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    chk_int({req, " pending outputs"}, exp_i.size(), 0);
    chk_int({req, " err pulses"}, err_seen - e0, (want_err < 0) ? experr - m0 : want_err);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250831));
    repeat (4) @(negedge clk);
    chk_int("R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_int("R1 out_valid", int'(out_valid), 0);
    chk_int("R1 err", int'(err), 0);
    chk_int("R1 in_ready", int'(in_ready), 1);
    mon_on = 1;

    // R2 R3 R4: single-parcel instructions, split parcel joined
    repeat (3) pair(1, 1, 1);
    pair(1, 1, 1);
    run("R4", 0);

    // R5: exact maximum length instruction
    pair(0, 1, 0); pair(0, 0, 0); pair(0, 0, 0); pair(1, 0, 1);
    run("R5", 0);

    // R8: overlong, then silent drop until a start
    pair(0, 0, 0); pair(0, 0, 0); pair(0, 0, 0); pair(0, 1, 0);
    run("R8", 1);

    // R6 R7: bad word discards, then orphan continuations
    stim.push_back(32'h0000_1234);
    pair(0, 0, 1); pair(0, 1, 1);
    run("R7", 3);

    // R6: repeated first word, then lone second word
    stim.push_back(mk_a(1, 1, 17'h1, 17'h2));
    pair(1, 0, 1);
    stim.push_back(mk_b(1, 17'h3, 17'h4));
    pair(1, 1, 0);
    run("R6", 2);

    // R9: heavy back-pressure with dense output
    bp_pct = 10;
    repeat (10) pair(1, 1, 1);
    pair(1, 0, 0);
    run("R9", 0);

    // R4 R9: random mix with some bad words
    bp_pct = 60;
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(99) < 3) stim.push_back({4'($urandom_range(14)), 28'($urandom)});
      pair($urandom_range(99) < 40, $urandom_range(99) < 40, $urandom_range(99) < 40);
    end
    pair(1, 1, 1);
    run("R9 random", -1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule